// File: doc/BRIEF.md
# Timer Interrupt Enable and Status Register

This block gathers the interrupt state of five timer channels into one 32-bit register word. Each channel has an enable bit and a sticky status bit. When a channel's counter runs out, it sends a one-cycle expiry pulse into the block. That pulse sets the channel's status bit whether or not the channel is enabled. Each channel also has a level interrupt output. It is high while both its status bit and its enable bit are set.

Software reaches the word through a plain address/data port at offset 0x44. A write updates the whole enable field. In the same write, every status bit written as one is cleared and every status bit written as zero is left alone. Software can therefore acknowledge any subset of pending channels and set the enable mask in one access. Reads are combinational and return zero at any other address. The interrupt outputs are registered, so each one lags the register contents by one clock.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: The register is reached only at address 0x44. A write to any other address changes nothing, and a read of any other address returns 0.
- R2: An expiry pulse on channel i sets status bit 5+i of the word, whether or not enable bit i is set. The bit stays set until software clears it.
- R3: Interrupt output i is high in the cycle after the one where status bit 5+i and enable bit i were both set. It is low otherwise, so clearing either bit lowers it one cycle later.
- R4: A write to 0x44 replaces enable bits [4:0] with bits [4:0] of the written data. The change is seen on the next read.
- R5: In a write to 0x44, each status bit [9:5] written as 1 is cleared and each one written as 0 keeps its value.
- R6: If an expiry pulse and a clearing write reach the same status bit in the same cycle, the bit ends up set.
- R7: While reset is asserted and after it is released, the word reads 0 and all interrupt outputs are low.
- R8: Bits [31:10] always read 0, and writing them has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Register address |
| we_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data |
| expire_i | input | 5 | Expiry pulse per channel |
| irq_o | output | 5 | Registered level interrupt per channel |

## Verification
The bench targets the following corner cases. For each, it notes how a wrong design would show up.

- **Expiry on a disabled channel.** A design that gated the status latch with the enable would lose the event. It would fail to raise the interrupt when the channel is enabled later.
- **Expiry and clear in the same cycle.** If clear took priority, the event would be silently dropped.
- **Mixed clear writes.** Writes with some status bits at one and others at zero expose a design that clears on zeros or clears the whole field.
- **Writes outside the register.** Writes to other addresses, and writes with the upper bits set, catch a design with loose address decode or bits that read back non-zero.
- **Interrupt timing.** The interrupt lines are compared every clock against a model that lags the register by one cycle. A combinational or two-stage output would be caught.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int unsigned NUM_CH_DEF = 5;
  localparam int unsigned ADDR_W_DEF = 8;
  localparam int unsigned DATA_W_DEF = 32;
  localparam logic [7:0]  REG_OFFSET_DEF = 8'h44;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10
  } acc_kind_e;
endpackage

// File: rtl/tmr_irq_regif.sv
module tmr_irq_regif #(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h44
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NUM_CH-1:0] status_i,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  import tmr_irq_pkg::*;

  localparam int unsigned STAT_LSB = NUM_CH;
  localparam int unsigned STAT_MSB = 2 * NUM_CH - 1;

  logic              sel;
  acc_kind_e         kind;
  logic [NUM_CH-1:0] en_q;

  assign sel  = (addr_i == REG_OFFSET);
  assign kind = !sel ? ACC_IDLE : (we_i ? ACC_WRITE : ACC_READ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (kind == ACC_WRITE) begin
      en_q <= wdata_i[NUM_CH-1:0];
    end
  end

  assign en_o  = en_q;
  assign clr_o = (kind == ACC_WRITE) ? wdata_i[STAT_MSB:STAT_LSB] : '0;

  always_comb begin
    rdata_o = '0;
    if (sel) begin
      rdata_o[NUM_CH-1:0]       = en_q;
      rdata_o[STAT_MSB:STAT_LSB] = status_i;
    end
  end

  // R4
  en_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_OFFSET) |=> (en_o == $past(wdata_i[NUM_CH-1:0])));

  // R1
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == REG_OFFSET) |=> $stable(en_o));
endmodule

// File: rtl/tmr_irq_status.sv
module tmr_irq_status #(
  parameter int unsigned NUM_CH = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] expire_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] status_o
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic st_q;

    // expiry takes priority over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          st_q <= 1'b0;
      else if (expire_i[i]) st_q <= 1'b1;
      else if (clr_i[i])    st_q <= 1'b0;
    end

    assign status_o[i] = st_q;

    // R2
    st_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_i[i] |=> status_o[i]);

    // R5
    st_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !expire_i[i]) |=> !status_o[i]);

    // R5
    st_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i[i] && !expire_i[i]) |=> $stable(status_o[i]));

    // R6
    st_race_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && expire_i[i]) |=> status_o[i]);
  end
endmodule

// File: rtl/tmr_irq_outreg.sv
module tmr_irq_outreg #(
  parameter int unsigned NUM_CH = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] status_i,
  input  logic [NUM_CH-1:0] en_i,
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0] irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= status_i & en_i;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
  parameter int unsigned NUM_CH = tmr_irq_pkg::NUM_CH_DEF,
  parameter int unsigned ADDR_W = tmr_irq_pkg::ADDR_W_DEF,
  parameter int unsigned DATA_W = tmr_irq_pkg::DATA_W_DEF,
  parameter logic [ADDR_W-1:0] REG_OFFSET = tmr_irq_pkg::REG_OFFSET_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_CH-1:0] expire_i,
  output logic [NUM_CH-1:0] irq_o
);
  localparam int unsigned USED_W = 2 * NUM_CH;

  logic [NUM_CH-1:0] en;
  logic [NUM_CH-1:0] clr;
  logic [NUM_CH-1:0] status;

  tmr_irq_regif #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_OFFSET(REG_OFFSET)
  ) u_regif (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .status_i(status), .en_o(en), .clr_o(clr),
    .rdata_o(rdata_o)
  );

  tmr_irq_status #(.NUM_CH(NUM_CH)) u_status (
    .clk_i(clk_i), .rst_ni(rst_ni), .expire_i(expire_i), .clr_i(clr),
    .status_o(status)
  );

  tmr_irq_outreg #(.NUM_CH(NUM_CH)) u_outreg (
    .clk_i(clk_i), .rst_ni(rst_ni), .status_i(status), .en_i(en),
    .irq_o(irq_o)
  );

  // R3
  irq_lag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == ($past(status) & $past(en))));

  // R8
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:USED_W] == '0);

  // R7
  rst_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (irq_o == '0 && status == '0 && en == '0));
endmodule

// File: tb/tmr_irq_ctrl_bench.sv
`timescale 1ns/1ps
module tmr_irq_ctrl_bench;
  localparam int N = 5;
  localparam logic [7:0] OFS = 8'h44;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [N-1:0] expire = '0;
  logic [31:0] rdata;
  logic [N-1:0] irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string tag = "R7";

  // behavioural model state
  int unsigned m_en = 0, m_st = 0, m_irq = 0;

  always #2.5 clk = ~clk;

  tmr_irq_ctrl u_tmr_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .expire_i(expire), .irq_o(irq)
  );

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_en = 0; m_st = 0; m_irq = 0;
    end else begin
      m_irq = m_st & m_en;
      if (we && addr == OFS) begin
        m_en = wdata & 32'h1f;
        m_st = m_st & ~((wdata >> 5) & 32'h1f);
      end
      m_st = m_st | int'(expire);
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", r, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      logic [31:0] exp_rd;
      exp_rd = (addr == OFS) ? ((m_st << 5) | m_en) : 32'h0;
      if (!rst_ni) begin
        chk("R7", rdata, 32'h0);
        chk("R7", {27'h0, irq}, 32'h0);
      end else begin
        chk((addr == OFS) ? tag : "R1", {22'h0, rdata[9:0]}, {22'h0, exp_rd[9:0]});
        chk("R8", {rdata[31:10], 10'h0}, 32'h0);
        chk("R3", {27'h0, irq}, m_irq);
      end
    end
  end

  task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d,
                      input logic [N-1:0] e);
    @(negedge clk); #1;
    we = w; addr = a; wdata = d; expire = e;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, OFS, 32'h0, '0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_ni = 1'b1;
    tag = "R7"; idle(2);
    // R4: enable field writes
    tag = "R4";
    step(1'b1, OFS, 32'h15, '0); idle(1);
    step(1'b1, OFS, 32'h0a, '0); idle(1);
    // R2: expiry while disabled still latches
    tag = "R2";
    step(1'b1, OFS, 32'h00, '0);
    step(1'b0, OFS, 32'h0, 5'b10101); idle(2);
    step(1'b1, OFS, 32'h1f, '0); idle(3);
    // R5: mixed clear, ones clear zeros keep
    tag = "R5";
    step(1'b0, OFS, 32'h0, 5'b01010); idle(1);
    step(1'b1, OFS, {22'h0, 5'b00110, 5'h1f}, '0); idle(2);
    step(1'b1, OFS, {22'h0, 5'b11111, 5'h1f}, '0); idle(2);
    // R6: collision, expiry wins
    tag = "R6";
    step(1'b1, OFS, {22'h0, 5'b11111, 5'h1f}, 5'b10001); idle(2);
    // R1: off-address write and read
    tag = "R1";
    step(1'b1, 8'h40, 32'h3ff, '0);
    step(1'b1, 8'h48, 32'h000, '0);
    step(1'b0, 8'h00, 32'h0, '0); idle(2);
    // R8: upper bits written
    tag = "R8";
    step(1'b1, OFS, 32'hfffffc1f, '0); idle(2);
    // random traffic
    tag = "R2";
    for (int k = 0; k < 3000; k++) begin
      logic [7:0] a;
      a = ($urandom % 4 == 0) ? 8'($urandom) : OFS;
      step(($urandom % 3) == 0, a, $urandom,
           (($urandom % 4) == 0) ? N'($urandom) : '0);
    end
    idle(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule